// File: doc/BRIEF.md
# Programmable-Length Recirculating Pattern Register

This block holds a serial bit pattern and plays it back without end. It is a chain of stages whose loop length can be set anywhere from one stage up to the full depth. The bit at the head of the chain is the output. In looping mode, that same bit is written back into the last active stage, so the chain itself is the pattern store and no separate memory is needed. In loading mode, the last active stage takes external serial data instead. Software or a controller first loads L bits, then switches to looping.

A pass counter tracks where the output is within the current L-bit pass. It raises a one-cycle marker on the shift that emits the final bit of each pass, so a sequencer can chain patterns or count repetitions. The serial data path has no valid/ready handshake. `shift_en` is the only qualifier and the block never applies back-pressure: every cycle with `shift_en` high consumes one input bit (when loading) and emits one output bit. A cycle with `shift_en` low moves nothing. `DEPTH` is expected to be a power of two.

Top module: `recirc_shift_reg`

## Requirements
- R1: After reset every stage holds 0, `dout` is 0, the pass counter is 0, and `pass_end` stays low while `shift_en` is low.
- R2: The active length is L = `len_sel` + 1. `dout` always shows stage 0. Each enabled clock moves every active stage's bit one place toward stage 0.
- R3: With `load_mode` = 1, an enabled clock writes `din` into stage `len_sel`. After L such clocks, the first bit loaded appears on `dout`.
- R4: With `load_mode` = 0, an enabled clock writes the bit leaving stage 0 into stage `len_sel`, so the `dout` sequence repeats with period exactly L shifts.
- R5: With `len_sel` = 0 (L = 1), looping keeps `dout` constant and `pass_end` is high on every enabled clock.
- R6: With `len_sel` = DEPTH-1, all DEPTH stages form the loop and a DEPTH-bit pattern replays unchanged.
- R7: While `shift_en` is low, all stages, `dout` and the pass counter hold their values, and `pass_end` is low.
- R8: `pass_end` is high, combinationally with `shift_en`, on the L-th enabled clock of each pass counted from reset or from the previous pass end. The counter then restarts at 0.
- R9: Stages with index above `len_sel` have no effect on `dout`. After the length is shortened, the output repeats the bits then held in stages 0..`len_sel`.
- R10: If `len_sel` is lowered so that the counter already equals or exceeds it, the next enabled clock raises `pass_end` and restarts the pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_mode | input | 1 | 1 = take `din` into the tail stage, 0 = recirculate stage 0 |
| shift_en | input | 1 | Advances the chain and the pass counter |
| din | input | 1 | Serial load data |
| len_sel | input | LEN_W (6) | Loop length minus one |
| dout | output | 1 | Stage 0, the pattern output |
| pass_end | output | 1 | High on the shift that emits the last bit of a pass |

## Verification
The hardest situation to reach from the ports is the one where stages beyond the active length hold stale data that must stay invisible. The stimulus creates it in three steps. It loads and replays a full-depth pseudo-random pattern, which leaves known bits in every stage. It then shortens the length and checks that the output is the exact six-bit prefix, repeating. The length-shrink wrap of the pass counter is reached the same way: the bench runs partway into a long pass and then drops `len_sel` below the count.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  localparam int unsigned RSR_DEFAULT_DEPTH = 64;

  typedef enum logic {
    MODE_LOOP = 1'b0,
    MODE_LOAD = 1'b1
  } rsr_mode_e;
endpackage

// File: rtl/rsr_stage.sv
module rsr_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic is_tail,
  input  logic tail_d,
  input  logic next_d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (shift_en) begin
      q <= is_tail ? tail_d : next_d;
    end
  end
endmodule

// File: rtl/rsr_tail_select.sv
module rsr_tail_select
  import rsr_pkg::*;
(
  input  logic load_mode,
  input  logic din,
  input  logic head_q,
  output logic tail_d
);
  rsr_mode_e mode;

  always_comb begin
    mode = rsr_mode_e'(load_mode);
    unique case (mode)
      MODE_LOAD: tail_d = din;
      default:   tail_d = head_q;
    endcase
  end
endmodule

// File: rtl/rsr_pass_counter.sv
module rsr_pass_counter #(
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [LEN_W-1:0] len_sel,
  output logic             pass_end
);
  logic [LEN_W-1:0] cnt_q;
  logic             last_bit;

  assign last_bit = (cnt_q >= len_sel);
  assign pass_end = shift_en && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (shift_en) begin
      cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
    end
  end

  // R8: a pass end restarts the count
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end |=> (cnt_q == '0));

  // R7: counter frozen without shift enable
  a_r7_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(cnt_q));
endmodule

// File: rtl/recirc_shift_reg.sv
module recirc_shift_reg
  import rsr_pkg::*;
#(
  parameter int unsigned DEPTH = RSR_DEFAULT_DEPTH,
  parameter int unsigned LEN_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_mode,
  input  logic             shift_en,
  input  logic             din,
  input  logic [LEN_W-1:0] len_sel,
  output logic             dout,
  output logic             pass_end
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] stage_q;
  logic             tail_d;

  rsr_tail_select u_tail (
    .load_mode (load_mode),
    .din       (din),
    .head_q    (stage_q[0]),
    .tail_d    (tail_d)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic next_d;
    if (i == LAST) begin : g_end
      assign next_d = 1'b0;
    end else begin : g_mid
      assign next_d = stage_q[i+1];
    end

    rsr_stage u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .is_tail  (len_sel == LEN_W'(i)),
      .tail_d   (tail_d),
      .next_d   (next_d),
      .q        (stage_q[i])
    );
  end

  rsr_pass_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .len_sel  (len_sel),
    .pass_end (pass_end)
  );

  assign dout = stage_q[0];

  // R7: output frozen without shift enable
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(dout));

  // R2: the bit in stage 1 advances to the output
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && len_sel != '0) |=> (dout == $past(stage_q[1])));

  // R3: loaded bit lands in the tail stage
  a_r3_load_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && load_mode) |=> (stage_q[$past(len_sel)] == $past(din)));

  // R5: a one-stage loop keeps its bit
  a_r5_single_loop: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_mode && len_sel == '0) |=> $stable(dout));

  // R7: no pass marker without shift enable
  a_r7_no_marker: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |-> !pass_end);
endmodule

// File: tb/recirc_shift_reg_tb_top.sv
module recirc_shift_reg_tb_top;
  localparam int DEPTH = 64;
  localparam int LW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_mode = 1'b0;
  logic shift_en = 1'b0;
  logic din = 1'b0;
  logic [LW-1:0] len_sel = '0;
  logic dout, pass_end;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  logic [DEPTH-1:0] big_pat;

  always #10 clk = ~clk;

  recirc_shift_reg #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .shift_en(shift_en),
    .din(din), .len_sel(len_sel), .dout(dout), .pass_end(pass_end)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one enabled clock; returns the output bit and marker seen before the edge
  task automatic do_shift(input logic ld, input logic d, output logic o, output logic pe);
    @(negedge clk);
    shift_en = 1'b1; load_mode = ld; din = d;
    #1;
    o = dout; pe = pass_end;
    @(posedge clk);
    #1;
    shift_en = 1'b0;
  endtask

  function automatic logic exp_marker();
    return exp_cnt >= int'(len_sel);
  endfunction

  function automatic void adv_cnt();
    if (exp_cnt >= int'(len_sel)) exp_cnt = 0; else exp_cnt++;
  endfunction

  task automatic t_reset();
    logic o, pe;
    @(negedge clk);
    check(dout == 1'b0, "R1 dout after reset", dout, 0);
    check(pass_end == 1'b0, "R1 marker idle", pass_end, 0);
    len_sel = 6'd3;
    for (int k = 0; k < 8; k++) begin
      bit em;
      em = exp_marker();
      do_shift(1'b0, 1'b0, o, pe);
      check(o == 1'b0, "R1 cleared stages", o, 0);
      check(pe == em, "R8 marker after reset", pe, em);
      adv_cnt();
    end
  endtask

  task automatic t_load_loop();
    logic o, pe;
    logic [7:0] pat = 8'hA5;
    len_sel = 6'd7;
    for (int k = 0; k < 8; k++) begin
      bit em;
      em = exp_marker();
      do_shift(1'b1, pat[k], o, pe);
      check(pe == em, "R8 marker in load", pe, em);
      adv_cnt();
    end
    for (int k = 0; k < 24; k++) begin
      bit em;
      em = exp_marker();
      do_shift(1'b0, 1'b1, o, pe);
      check(o == pat[k%8], "R3 R4 looped bit", o, pat[k%8]);
      check(pe == em, "R8 marker in loop", pe, em);
      adv_cnt();
    end
  endtask

  task automatic t_hold();
    logic o, pe;
    logic [7:0] pat = 8'hA5;
    load_mode = 1'b1; din = 1'b1;
    repeat (10) begin
      @(negedge clk);
      check(dout == pat[0], "R7 output held", dout, pat[0]);
      check(pass_end == 1'b0, "R7 marker low", pass_end, 0);
    end
    for (int k = 0; k < 8; k++) begin
      bit em;
      em = exp_marker();
      do_shift(1'b0, 1'b0, o, pe);
      check(o == pat[k], "R7 resume sequence", o, pat[k]);
      check(pe == em, "R7 R8 counter held", pe, em);
      adv_cnt();
    end
  endtask

  task automatic t_len_one();
    logic o, pe;
    len_sel = 6'd0;
    begin
      bit em;
      em = exp_marker();
      do_shift(1'b1, 1'b1, o, pe);
      check(pe == em, "R10 R5 marker on load", pe, em);
      adv_cnt();
    end
    for (int k = 0; k < 5; k++) begin
      do_shift(1'b0, 1'b0, o, pe);
      check(o == 1'b1, "R5 single bit held", o, 1);
      check(pe == 1'b1, "R5 marker every shift", pe, 1);
      adv_cnt();
    end
  endtask

  task automatic t_full_depth();
    logic o, pe;
    logic [15:0] lfsr = 16'hACE1;
    for (int k = 0; k < DEPTH; k++) begin
      big_pat[k] = lfsr[0];
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
    len_sel = 6'(DEPTH - 1);
    for (int k = 0; k < DEPTH; k++) begin
      do_shift(1'b1, big_pat[k], o, pe);
      adv_cnt();
    end
    for (int k = 0; k < 2*DEPTH; k++) begin
      bit em;
      em = exp_marker();
      do_shift(1'b0, 1'b0, o, pe);
      check(o == big_pat[k%DEPTH], "R6 full depth replay", o, big_pat[k%DEPTH]);
      check(pe == em, "R6 R8 marker full depth", pe, em);
      adv_cnt();
    end
  endtask

  task automatic t_shorten();
    logic o, pe;
    len_sel = 6'd5;
    exp_cnt = exp_cnt;
    for (int k = 0; k < 18; k++) begin
      bit em;
      em = exp_marker();
      do_shift(1'b0, 1'b0, o, pe);
      check(o == big_pat[k%6], "R9 tail stages ignored", o, big_pat[k%6]);
      check(pe == em, "R9 marker after shorten", pe, em);
      adv_cnt();
    end
  endtask

  task automatic t_wrap();
    logic o, pe;
    len_sel = 6'd40;
    while (exp_cnt != 0) begin
      do_shift(1'b0, 1'b0, o, pe);
      adv_cnt();
    end
    for (int k = 0; k < 20; k++) begin
      do_shift(1'b0, 1'b0, o, pe);
      check(pe == 1'b0, "R10 no marker mid pass", pe, 0);
      adv_cnt();
    end
    len_sel = 6'd2;
    do_shift(1'b0, 1'b0, o, pe);
    check(pe == 1'b1, "R10 marker on shrink", pe, 1);
    adv_cnt();
    for (int k = 0; k < 6; k++) begin
      bit em;
      em = (k % 3) == 2;
      do_shift(1'b0, 1'b0, o, pe);
      check(pe == em, "R10 restarted pass", pe, em);
      adv_cnt();
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_load_loop();
    t_hold();
    t_len_one();
    t_full_depth();
    t_shorten();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule